// File: doc/BRIEF.md
# Phase-Shiftable Carrier Divider

This block divides a radio carrier clock by a programmable 16-bit ratio and produces two waveforms from it. A free-running up-counter runs on the carrier clock. It wraps to zero on the cycle after it reaches the period limit C, so one output period lasts C+1 carrier cycles. Two more compare points, A and B, sit inside that period. Output `waveA` is set when the count reaches A and is cleared when the count reaches C. Output `waveB` is set by a rising edge on the event input and is cleared when the count reaches B. The event input is meant to be `waveA` looped back outside the block, which gives a waveform close to 50% duty for the default compare points.

Software drives the block through a one-cycle command port that runs in the carrier clock domain. The commands are:
- load a ratio, which also sets the default compare points;
- write A or write B directly;
- shift the phase of both outputs by a signed step, taken modulo the period;
- stop or start the counter;
- restart the counter at zero.

Top module: `carrier_phase_div`

## Requirements
- R1: After reset `waveA` and `waveB` are 0, the counter runs, C is 128, A is 1 and B is 65, so `waveA` repeats every 129 cycles and is high for 127 of them.
- R2: After a ratio load with value N (opcode 1, N on `cmdData`, N >= 8), both outputs repeat every N+1 carrier cycles.
- R3: A ratio load with value N sets C = N, A = 1 and B = 1 + (N >> 1). `waveA` is then high for C - A cycles per period. With `evtIn` tied to `waveA`, `waveB` is high for (B - A - 3) mod (C+1) cycles.
- R4: `waveA` goes high on the clock after the count equals A and low on the clock after the count equals C. When A equals C, the clear wins and `waveA` stays low (A is written with opcode 6).
- R5: `evtIn` passes through a two-stage synchroniser and a rising-edge detector. `waveB` goes high on the second clock edge after the first edge that samples `evtIn` high. With loopback, `waveB` rises 3 cycles after `waveA` rises.
- R6: `waveB` goes low on the clock after the count equals B. When a detected event and a B match fall in the same cycle, the set wins (B is written with opcode 7).
- R7: A phase step (opcode 2, signed 16-bit step on `cmdData`) replaces A with (A + step) mod C and B with (B + step) mod C. This moves both outputs' rising positions by the step.
- R8: For a negative step the stored result is the non-negative residue in 0 to C-1, not a signed remainder. After any phase step with C > 1, A is below C.
- R9: If a phase step leaves A at 0, A becomes 1 and B becomes its reduced value plus 1, so A is never 0 after a phase step.
- R10: A stop command (opcode 4) freezes the counter, and `waveA` holds its level while stopped. A start command (opcode 3) resumes counting at the same N+1 period.
- R11: A restart command (opcode 5) sets the counter to 0 at the clock edge that accepts it. If `waveA` is high at that point, it then falls on the (C+1)th edge after that accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier clock; all state runs on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command strobe, one cycle per command |
| cmdOp | input | 3 | Opcode: 0 none, 1 ratio load, 2 phase step, 3 start, 4 stop, 5 restart, 6 write A, 7 write B |
| cmdData | input | 16 | Ratio, compare value, or signed phase step |
| evtIn | input | 1 | Asynchronous event that sets `waveB` on its rising edge |
| waveA | output | 1 | Output set at the A match, cleared at the C match |
| waveB | output | 1 | Output set by a detected event, cleared at the B match |

## Verification
The bench uses negative phase steps that must wrap to the top of the period. A design with a raw signed remainder would store an out-of-range A and show a wrong `waveA` high time. It also uses a step that lands A exactly on zero: without the guard, `waveA` would never be set in the right place and its high time would be off by one. It places A on C, and B on the cycle where the looped-back event is detected, to check each output's priority; the wrong order leaves `waveA` toggling or `waveB` stuck low. It also measures the synchroniser lag, the frozen outputs while stopped, and the distance from a restart to the next fall, which catch an extra or missing register stage or a restart that does not clear the count.

// File: rtl/cpd_pkg.sv
package cpd_pkg;

  localparam int CNT_W = 16;

  localparam logic [2:0] OP_NOP     = 3'd0;
  localparam logic [2:0] OP_SETDIV  = 3'd1;
  localparam logic [2:0] OP_PHASE   = 3'd2;
  localparam logic [2:0] OP_START   = 3'd3;
  localparam logic [2:0] OP_STOP    = 3'd4;
  localparam logic [2:0] OP_RESTART = 3'd5;
  localparam logic [2:0] OP_WRA     = 3'd6;
  localparam logic [2:0] OP_WRB     = 3'd7;

  typedef struct packed {
    logic [CNT_W-1:0] a;
    logic [CNT_W-1:0] b;
    logic [CNT_W-1:0] c;
  } cmpSet_t;

  typedef struct packed {
    logic run;
    logic restart;
  } strobe_t;

  // (base + step) reduced into 0..modv-1; modv must be non-zero
  function automatic logic [CNT_W-1:0] wrapAdd(
    input logic [CNT_W-1:0]        base,
    input logic signed [CNT_W-1:0] step,
    input logic [CNT_W-1:0]        modv
  );
    logic signed [CNT_W+1:0] sum;
    logic signed [CNT_W+1:0] m;
    logic signed [CNT_W+1:0] r;
    sum = $signed({2'b00, base}) + $signed({{2{step[CNT_W-1]}}, step});
    m   = $signed({2'b00, modv});
    r   = sum % m;
    if (r < 0) r = r + m;
    return r[CNT_W-1:0];
  endfunction

endpackage

// File: rtl/cpd_ctrl.sv
module cpd_ctrl
  import cpd_pkg::*;
#(
  parameter int DEF_DIV = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [2:0]       cmdOp,
  input  logic [CNT_W-1:0] cmdData,
  output cmpSet_t          cmpSet,
  output strobe_t          strobes
);

  localparam logic [CNT_W-1:0] DEF_C = CNT_W'(DEF_DIV);
  localparam logic [CNT_W-1:0] DEF_A = CNT_W'(1);
  localparam logic [CNT_W-1:0] DEF_B = CNT_W'(1 + (DEF_DIV >> 1));

  cmpSet_t cmpQ;
  logic    runQ;

  logic [CNT_W-1:0] phaseA;
  logic [CNT_W-1:0] phaseB;

  always_comb begin
    phaseA = cmpQ.a;
    phaseB = cmpQ.b;
    if (cmpQ.c != '0) begin
      phaseA = wrapAdd(cmpQ.a, $signed(cmdData), cmpQ.c);
      phaseB = wrapAdd(cmpQ.b, $signed(cmdData), cmpQ.c);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpQ.a <= DEF_A;
      cmpQ.b <= DEF_B;
      cmpQ.c <= DEF_C;
      runQ   <= 1'b1;
    end else if (cmdValid) begin
      case (cmdOp)
        OP_SETDIV: begin
          cmpQ.c <= cmdData;
          cmpQ.a <= CNT_W'(1);
          cmpQ.b <= CNT_W'(1) + (cmdData >> 1);
        end
        OP_PHASE: begin
          if (cmpQ.c != '0) begin
            if (phaseA == '0) begin
              cmpQ.a <= CNT_W'(1);
              cmpQ.b <= phaseB + CNT_W'(1);
            end else begin
              cmpQ.a <= phaseA;
              cmpQ.b <= phaseB;
            end
          end
        end
        OP_START: runQ   <= 1'b1;
        OP_STOP:  runQ   <= 1'b0;
        OP_WRA:   cmpQ.a <= cmdData;
        OP_WRB:   cmpQ.b <= cmdData;
        default: ;
      endcase
    end
  end

  assign cmpSet          = cmpQ;
  assign strobes.run     = runQ;
  assign strobes.restart = cmdValid && (cmdOp == OP_RESTART);

endmodule

// File: rtl/cpd_datapath.sv
module cpd_datapath
  import cpd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  cmpSet_t cmpSet,
  input  strobe_t strobes,
  input  logic    evtIn,
  output logic    waveA,
  output logic    waveB
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [CNT_W-1:0]       count;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   evtPrev;
  logic                   evtRise;
  logic                   hitA, hitB, hitC;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 count <= '0;
    else if (strobes.restart)  count <= '0;
    else if (strobes.run)      count <= (count == cmpSet.c) ? '0 : count + CNT_W'(1);
  end

  assign hitA = strobes.run && (count == cmpSet.a);
  assign hitB = strobes.run && (count == cmpSet.b);
  assign hitC = strobes.run && (count == cmpSet.c);

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ[s] <= 1'b0;
        else       syncQ[s] <= evtIn;
    end else begin : g_rest
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ[s] <= 1'b0;
        else       syncQ[s] <= syncQ[s-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) evtPrev <= 1'b0;
    else       evtPrev <= syncQ[LAST];
  end

  assign evtRise = syncQ[LAST] && !evtPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waveA <= 1'b0;
      waveB <= 1'b0;
    end else begin
      if (hitC)      waveA <= 1'b0;
      else if (hitA) waveA <= 1'b1;
      if (evtRise)   waveB <= 1'b1;
      else if (hitB) waveB <= 1'b0;
    end
  end

endmodule

// File: rtl/carrier_phase_div.sv
module carrier_phase_div
  import cpd_pkg::*;
#(
  parameter int DEF_DIV     = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [2:0]  cmdOp,
  input  logic [15:0] cmdData,
  input  logic        evtIn,
  output logic        waveA,
  output logic        waveB
);

  cmpSet_t cmpSet;
  strobe_t strobes;

  cpd_ctrl #(.DEF_DIV(DEF_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdData(cmdData), .cmpSet(cmpSet), .strobes(strobes)
  );

  cpd_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .cmpSet(cmpSet), .strobes(strobes),
    .evtIn(evtIn), .waveA(waveA), .waveB(waveB)
  );

endmodule

// File: rtl/cpd_checker.sv
module cpd_checker
  import cpd_pkg::*;
#(
  parameter int DEF_DIV = 128
) (
  input logic        clk,
  input logic        rstN,
  input logic        cmdValid,
  input logic [2:0]  cmdOp,
  input logic [15:0] cmdData,
  input logic        waveA,
  input cmpSet_t     cmp,
  input strobe_t     stb
);

  // R1: defaults present when reset releases
  p_reset_defaults_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (cmp.c == CNT_W'(DEF_DIV) && cmp.a == CNT_W'(1) && !waveA));

  // R3: ratio load sets all three compare points
  p_ratio_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == OP_SETDIV) |=>
      (cmp.c == $past(cmdData) && cmp.a == CNT_W'(1) &&
       cmp.b == CNT_W'(1) + ($past(cmdData) >> 1)));

  // R8: phase step keeps A inside the period
  p_phase_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == OP_PHASE && cmp.c > CNT_W'(1)) |=>
      (cmp.a < cmp.c && cmp.b <= cmp.c));

  // R9: A is never left at zero by a phase step
  p_zero_guard_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == OP_PHASE && cmp.c != '0) |=> (cmp.a != '0));

  // R10: a stopped counter leaves waveA untouched
  p_hold_when_stopped_r10: assert property (@(posedge clk) disable iff (!rstN)
    !stb.run |=> $stable(waveA));

endmodule

bind carrier_phase_div cpd_checker #(.DEF_DIV(DEF_DIV)) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
  .cmdData(cmdData), .waveA(waveA), .cmp(cmpSet), .stb(strobes)
);

// File: tb/carrier_phase_div_test.sv
module carrier_phase_div_test;

  localparam int K_HIGH_A = 0;
  localparam int K_PER_A  = 1;
  localparam int K_HIGH_B = 2;
  localparam int K_LAG    = 3;

  typedef struct {
    int    kind;
    int    val;
    string req;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [2:0]  cmdOp = 3'd0;
  logic [15:0] cmdData = 16'd0;
  logic        waveA, waveB;
  logic        evtIn;

  int passCnt = 0;
  int failCnt = 0;
  int cyc = 0;
  bit done = 1'b0;
  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  assign evtIn = waveA;

  carrier_phase_div uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdData(cmdData), .evtIn(evtIn), .waveA(waveA), .waveB(waveB)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    if (ok) passCnt++;
    else begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [15:0] d);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdData = d;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 3'd0; cmdData = 16'd0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectMeas(input int kind, input int val, input string req);
    expItem_t it;
    it.kind = kind; it.val = val; it.req = req;
    expQ.push_back(it);
    wait (expQ.size() == 0);
  endtask

  // monitor: measures pulse widths, periods and lag, compares with queue head
  int  aRiseT = 0, bRiseT = 0;
  bit  aSeen = 1'b0;
  logic prevA = 1'b0, prevB = 1'b0;

  task automatic offer(input int kind, input int meas);
    if (expQ.size() > 0 && expQ[0].kind == kind) begin
      check(meas == expQ[0].val, expQ[0].req, meas, expQ[0].val);
      void'(expQ.pop_front());
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (waveA && !prevA) begin
        if (aSeen) offer(K_PER_A, cyc - aRiseT);
        aRiseT = cyc; aSeen = 1'b1;
      end
      if (!waveA && prevA && aSeen) offer(K_HIGH_A, cyc - aRiseT);
      if (waveB && !prevB) begin
        if (aSeen) offer(K_LAG, cyc - aRiseT);
        bRiseT = cyc;
      end
      if (!waveB && prevB) offer(K_HIGH_B, cyc - bRiseT);
    end
    prevA = waveA;
    prevB = waveB;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
      $finish;
    end
  end

  initial begin
    int n;
    idle(3);
    check(waveA == 1'b0, "R1 waveA at reset", int'(waveA), 0);
    check(waveB == 1'b0, "R1 waveB at reset", int'(waveB), 0);
    rstN = 1'b1;
    idle(300);
    expectMeas(K_PER_A, 129, "R1 default period");
    expectMeas(K_HIGH_A, 127, "R1 default waveA high");

    // ratio 100
    issue(3'd1, 16'd100);
    idle(250);
    expectMeas(K_PER_A, 101, "R2 period N=100");
    expectMeas(K_HIGH_A, 99, "R3 waveA high N=100");
    expectMeas(K_HIGH_B, 47, "R3 waveB high N=100");
    expectMeas(K_LAG, 3, "R5 event lag");

    // ratio 20
    issue(3'd1, 16'd20);
    idle(80);
    expectMeas(K_PER_A, 21, "R2 period N=20");
    expectMeas(K_HIGH_A, 19, "R3 waveA high N=20");
    expectMeas(K_HIGH_B, 7, "R3 waveB high N=20");

    // phase steps on N=100: A=1,B=51
    issue(3'd1, 16'd100);
    idle(250);
    issue(3'd2, 16'd10);            // A=11, B=61
    idle(250);
    expectMeas(K_HIGH_A, 89, "R7 waveA high after +10");
    expectMeas(K_HIGH_B, 47, "R7 waveB high after +10");
    expectMeas(K_PER_A, 101, "R7 period kept");

    issue(3'd2, 16'hFFEB);          // -21: A=90, B=40
    idle(250);
    expectMeas(K_HIGH_A, 10, "R8 waveA high after -21");
    expectMeas(K_HIGH_B, 48, "R8 waveB high after -21");
    expectMeas(K_LAG, 3, "R8 lag after wrap");

    issue(3'd2, 16'd10);            // A->0 guarded to 1, B=51
    idle(250);
    expectMeas(K_HIGH_A, 99, "R9 waveA high after zero guard");
    expectMeas(K_HIGH_B, 47, "R9 waveB high after zero guard");

    // R4: A equal to C, clear wins
    issue(3'd6, 16'd100);
    idle(250);
    n = 0;
    for (int i = 0; i < 303; i++) begin
      @(negedge clk);
      if (waveA) n++;
    end
    check(n == 0, "R4 clear beats set", n, 0);
    issue(3'd1, 16'd100);
    idle(250);
    expectMeas(K_HIGH_A, 99, "R4 waveA recovers");

    // R6: B on the event-detect cycle, set wins
    issue(3'd7, 16'd4);
    idle(250);
    n = 0;
    for (int i = 0; i < 303; i++) begin
      @(negedge clk);
      if (!waveB) n++;
    end
    check(n == 0, "R6 event set beats B clear", n, 0);
    issue(3'd1, 16'd100);
    idle(250);
    expectMeas(K_HIGH_B, 47, "R6 waveB recovers");

    // R10: stop freezes outputs
    begin
      logic holdA, holdB;
      issue(3'd4, 16'd0);
      idle(10);
      holdA = waveA; holdB = waveB;
      n = 0;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (waveA != holdA || waveB != holdB) n++;
      end
      check(n == 0, "R10 outputs frozen while stopped", n, 0);
      issue(3'd3, 16'd0);
      idle(250);
      expectMeas(K_PER_A, 101, "R10 period after start");
    end

    // R11: restart while waveA is high
    @(negedge clk);
    while (waveA) @(negedge clk);
    while (!waveA) @(negedge clk);
    idle(5);
    issue(3'd5, 16'd0);
    n = 1;
    while (waveA && n < 1000) begin
      @(negedge clk);
      n++;
    end
    check(n == 102, "R11 fall after restart", n, 102);

    done = 1'b1;
    $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
    $finish;
  end

endmodule